// File: doc/BRIEF.md
# Stack Pointer Adjust Unit

This unit holds a stack pointer register and, for each push or pop request, computes the memory address of the stack access and the new pointer value. A push first lowers the pointer by the step and then uses the lowered pointer as the access address. A pop uses the current pointer as the access address and then raises it. A pop-and-release form also adds an unsigned byte count, which frees parameters left on the stack by the caller.

The operand-size code sets the step. An address-size code (16, 32 or 64 bits) sets how many low bits of the pointer take part in addressing and wrap-around. Bits above that width are kept as they are. A segment-selector push is padded to the full stack slot. In the two legacy address sizes the segment base is added to form the address. In the 64-bit size the base is forced to zero.

A direct load replaces the pointer and takes priority over any push or pop in the same cycle. Each accepted push or pop gives a one-cycle response pulse on the cycle after the request. The response carries the registered address, and the pointer output shows the updated pointer. The unit does not check alignment, segment limits or faults.

Top module: `stkptr_unit`

## Requirements
- R1: A push (op code 0) lowers the pointer by the step. The response address is the effective base plus the lowered pointer, truncated to the address size.
- R2: A pop (op code 1, and the reserved code 3) uses the effective base plus the current truncated pointer as the address. The pointer then rises by the step.
- R3: Operand-size code 0 gives a step of 2 bytes, code 1 gives 4 bytes, and codes 2 and 3 give 8 bytes.
- R4: With the selector flag set, the step is the stack slot width: 2, 4 or 8 bytes for address-size codes 0, 1 and 2 or 3. The operand-size code is ignored in this case.
- R5: A 2-byte push on a 32-bit stack moves the pointer by exactly 2, even when this leaves it off a 4-byte boundary. No other behaviour changes.
- R6: With address-size code 0, the low 16 bits wrap modulo 2^16. Bits 63:16 of the pointer stay unchanged, and only the low 16 bits enter the address.
- R7: With address-size code 1, the low 32 bits wrap modulo 2^32. Bits 63:32 stay unchanged, and only the low 32 bits enter the address.
- R8: With address-size code 2 or 3, the segment base is ignored (treated as zero). The full 64-bit pointer is used.
- R9: A pop-and-release (op code 2) raises the pointer by the step plus the request's unsigned release count. The access address is the same as for a plain pop.
- R10: A load replaces the pointer on the next cycle and overrides a push or pop in the same cycle. That push or pop gets no response and has no effect.
- R11: The response valid is high for exactly the cycle after each accepted push or pop and low otherwise. The pointer stays unchanged on idle cycles.
- R12: Synchronous active-high reset clears the pointer, the response valid and the response address to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Push or pop request this cycle |
| req_op | input | 2 | 0 push, 1 pop, 2 pop-and-release, 3 pop |
| req_osize | input | 2 | Operand size: 0 two bytes, 1 four, 2/3 eight |
| req_asize | input | 2 | Address size: 0 16-bit, 1 32-bit, 2/3 64-bit |
| req_selpush | input | 1 | Value is a segment selector; pad to stack slot |
| req_rel | input | REL_W | Extra release byte count for op 2 |
| load_en | input | 1 | Replace pointer with load_val |
| load_val | input | ADDR_W | Value loaded into the pointer |
| seg_base | input | ADDR_W | Stack segment base (legacy sizes only) |
| rsp_valid | output | 1 | One-cycle response for a push or pop |
| rsp_addr | output | ADDR_W | Effective address of the stack access |
| rsp_ptr | output | ADDR_W | Current (updated) stack pointer |

## Verification
The bench drives 16-bit pushes and pops across the 0000h boundary with non-zero upper pointer bits. A unit that carried into or cleared bits 63:16 would show a changed upper half. A 32-bit push below zero is treated the same way for bits 63:32. Selector pushes on each stack width separate a unit that steps by the operand size from one that pads to the slot. An odd 2-byte push on a 32-bit stack catches any rounding to alignment.

A non-zero segment base in 64-bit mode exposes an adder that fails to zero it. A load issued together with a push must swallow the push. A stray response or a pointer off by the slot size would show that it did not.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;
  localparam int unsigned LANE_W = 16;

  typedef enum logic [1:0] {
    OP_PUSH   = 2'd0,
    OP_POP    = 2'd1,
    OP_POPREL = 2'd2,
    OP_POPALT = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    AW_16  = 2'd0,
    AW_32  = 2'd1,
    AW_64  = 2'd2,
    AW_64B = 2'd3
  } stk_aw_e;

  typedef enum logic [1:0] {
    OW_2  = 2'd0,
    OW_4  = 2'd1,
    OW_8  = 2'd2,
    OW_8B = 2'd3
  } stk_ow_e;
endpackage

// File: rtl/stkptr_step.sv
module stkptr_step
  import stkptr_pkg::*;
(
  input  logic [1:0] osize,
  input  logic [1:0] asize,
  input  logic       selpush,
  output logic [3:0] step_bytes
);
  logic [3:0] op_bytes;
  logic [3:0] slot_bytes;

  always_comb begin
    case (osize)
      OW_2:    op_bytes = 4'd2;
      OW_4:    op_bytes = 4'd4;
      default: op_bytes = 4'd8;
    endcase
    case (asize)
      AW_16:   slot_bytes = 4'd2;
      AW_32:   slot_bytes = 4'd4;
      default: slot_bytes = 4'd8;
    endcase
    step_bytes = selpush ? slot_bytes : op_bytes;
  end
endmodule

// File: rtl/stkptr_lane_add.sv
module stkptr_lane_add
  import stkptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] delta,
  input  logic [1:0]        asize,
  output logic [ADDR_W-1:0] nxt
);
  localparam int unsigned LANES = ADDR_W / LANE_W;

  logic [ADDR_W-1:0] sum;
  assign sum = cur + delta;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign nxt[g*LANE_W +: LANE_W] = sum[g*LANE_W +: LANE_W];
    end else if (g == 1) begin : g_mid
      assign nxt[g*LANE_W +: LANE_W] = (asize == AW_16) ?
        cur[g*LANE_W +: LANE_W] : sum[g*LANE_W +: LANE_W];
    end else begin : g_high
      assign nxt[g*LANE_W +: LANE_W] = asize[1] ?
        sum[g*LANE_W +: LANE_W] : cur[g*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/stkptr_ea.sv
module stkptr_ea
  import stkptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [1:0]        asize,
  output logic [ADDR_W-1:0] ea
);
  localparam int unsigned LANES = ADDR_W / LANE_W;

  logic [ADDR_W-1:0] trunc;
  logic [ADDR_W-1:0] eff_base;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign trunc[g*LANE_W +: LANE_W] = ptr[g*LANE_W +: LANE_W];
    end else if (g == 1) begin : g_mid
      assign trunc[g*LANE_W +: LANE_W] = (asize == AW_16) ?
        '0 : ptr[g*LANE_W +: LANE_W];
    end else begin : g_high
      assign trunc[g*LANE_W +: LANE_W] = asize[1] ?
        ptr[g*LANE_W +: LANE_W] : '0;
    end
  end

  assign eff_base = asize[1] ? '0 : base;
  assign ea       = eff_base + trunc;
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 64,
  parameter int unsigned     REL_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_PTR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_osize,
  input  logic [1:0]        req_asize,
  input  logic              req_selpush,
  input  logic [REL_W-1:0]  req_rel,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic [ADDR_W-1:0] seg_base,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_ptr
);
  localparam int unsigned STEP_W = 4;

  logic [ADDR_W-1:0] ptr_q;
  logic              rsp_valid_q;
  logic [ADDR_W-1:0] rsp_addr_q;

  logic [STEP_W-1:0] step_bytes;
  logic [ADDR_W-1:0] step_ext;
  logic [ADDR_W-1:0] rel_ext;
  logic [ADDR_W-1:0] delta;
  logic [ADDR_W-1:0] nxt_ptr;
  logic [ADDR_W-1:0] access_ptr;
  logic [ADDR_W-1:0] access_ea;
  logic              is_push;
  logic              is_rel;

  stkptr_step u_step (
    .osize      (req_osize),
    .asize      (req_asize),
    .selpush    (req_selpush),
    .step_bytes (step_bytes)
  );

  always_comb begin
    is_push    = (req_op == OP_PUSH);
    is_rel     = (req_op == OP_POPREL);
    step_ext   = {{(ADDR_W-STEP_W){1'b0}}, step_bytes};
    rel_ext    = is_rel ? {{(ADDR_W-REL_W){1'b0}}, req_rel} : '0;
    delta      = is_push ? (~step_ext + 1'b1) : (step_ext + rel_ext);
    access_ptr = is_push ? nxt_ptr : ptr_q;
  end

  stkptr_lane_add #(.ADDR_W(ADDR_W)) u_add (
    .cur   (ptr_q),
    .delta (delta),
    .asize (req_asize),
    .nxt   (nxt_ptr)
  );

  stkptr_ea #(.ADDR_W(ADDR_W)) u_ea (
    .base  (seg_base),
    .ptr   (access_ptr),
    .asize (req_asize),
    .ea    (access_ea)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q       <= RESET_PTR;
      rsp_valid_q <= 1'b0;
      rsp_addr_q  <= '0;
    end else if (load_en) begin
      ptr_q       <= load_val;
      rsp_valid_q <= 1'b0;
    end else if (req_valid) begin
      ptr_q       <= nxt_ptr;
      rsp_valid_q <= 1'b1;
      rsp_addr_q  <= access_ea;
    end else begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_addr  = rsp_addr_q;
  assign rsp_ptr   = ptr_q;
endmodule

// File: rtl/stkptr_unit_chk.sv
module stkptr_unit_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned REL_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [1:0]        req_osize,
  input logic [1:0]        req_asize,
  input logic              req_selpush,
  input logic [REL_W-1:0]  req_rel,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_val,
  input logic [ADDR_W-1:0] seg_base,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [ADDR_W-1:0] rsp_ptr
);
  logic take;
  assign take = req_valid && !load_en;

  p_reset_r12: assert property (@(posedge clk)
    rst |=> !rsp_valid && rsp_addr == '0);

  p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (rsp_ptr == $past(load_val)) && !rsp_valid);

  p_resp_r11: assert property (@(posedge clk) disable iff (rst)
    take |=> rsp_valid);

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !load_en) |=> !rsp_valid && $stable(rsp_ptr));

  p_upper16_r6: assert property (@(posedge clk) disable iff (rst)
    (take && req_asize == 2'd0) |=>
      rsp_ptr[ADDR_W-1:16] == $past(rsp_ptr[ADDR_W-1:16]));

  p_upper32_r7: assert property (@(posedge clk) disable iff (rst)
    (take && req_asize == 2'd1) |=>
      rsp_ptr[ADDR_W-1:32] == $past(rsp_ptr[ADDR_W-1:32]));

  p_flat_push_r8: assert property (@(posedge clk) disable iff (rst)
    (take && req_asize[1] && req_op == 2'd0) |=> rsp_addr == rsp_ptr);

  p_flat_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (take && req_asize[1] && req_op != 2'd0) |=> rsp_addr == $past(rsp_ptr));

  p_push_down_r1: assert property (@(posedge clk) disable iff (rst)
    (take && req_asize[1] && req_op == 2'd0 && !req_selpush && req_osize[1]) |=>
      rsp_ptr == $past(rsp_ptr) - 64'd8);

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (take && req_asize[1] && req_op == 2'd2 && !req_selpush && req_osize[1]) |=>
      rsp_ptr == $past(rsp_ptr) + 64'd8 + {{(ADDR_W-REL_W){1'b0}}, $past(req_rel)});
endmodule

bind stkptr_unit stkptr_unit_chk #(.ADDR_W(ADDR_W), .REL_W(REL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_osize   (req_osize),
  .req_asize   (req_asize),
  .req_selpush (req_selpush),
  .req_rel     (req_rel),
  .load_en     (load_en),
  .load_val    (load_val),
  .seg_base    (seg_base),
  .rsp_valid   (rsp_valid),
  .rsp_addr    (rsp_addr),
  .rsp_ptr     (rsp_ptr)
);

// File: tb/stkptr_unit_bench.sv
module stkptr_unit_bench;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned REL_W  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic [1:0]        req_op;
  logic [1:0]        req_osize;
  logic [1:0]        req_asize;
  logic              req_selpush;
  logic [REL_W-1:0]  req_rel;
  logic              load_en;
  logic [ADDR_W-1:0] load_val;
  logic [ADDR_W-1:0] seg_base;
  logic              rsp_valid;
  logic [ADDR_W-1:0] rsp_addr;
  logic [ADDR_W-1:0] rsp_ptr;

  always #4 clk = ~clk;

  stkptr_unit #(.ADDR_W(ADDR_W), .REL_W(REL_W)) u_stkptr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_osize(req_osize), .req_asize(req_asize), .req_selpush(req_selpush),
    .req_rel(req_rel), .load_en(load_en), .load_val(load_val),
    .seg_base(seg_base), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_ptr(rsp_ptr)
  );

  typedef struct {
    logic [63:0] addr;
    logic [63:0] ptr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  exp_t        got;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [63:0] model_ptr = '0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] lmask(logic [1:0] as);
    if (as == 2'd0) return 64'h0000_0000_0000_FFFF;
    if (as == 2'd1) return 64'h0000_0000_FFFF_FFFF;
    return '1;
  endfunction

  function automatic logic [63:0] stepv(logic [1:0] os, logic [1:0] as, logic sel);
    logic [1:0] c;
    c = sel ? as : os;
    if (c == 2'd0) return 64'd2;
    if (c == 2'd1) return 64'd4;
    return 64'd8;
  endfunction

  // Driver: called at a falling edge; computes the expected result from the
  // requirements, queues it and presents the request for one cycle.
  task automatic issue(logic [1:0] op, logic [1:0] os, logic [1:0] as, logic sel,
                       logic [15:0] rel, logic [63:0] base, string tag);
    exp_t        e;
    logic [63:0] m, st, np, b;
    m  = lmask(as);
    st = stepv(os, as, sel);
    b  = as[1] ? 64'd0 : base;
    if (op == 2'd0) begin
      np     = (model_ptr & ~m) | ((model_ptr - st) & m);
      e.addr = b + (np & m);
    end else begin
      np     = (model_ptr & ~m) |
               ((model_ptr + st + ((op == 2'd2) ? {48'd0, rel} : 64'd0)) & m);
      e.addr = b + (model_ptr & m);
    end
    e.ptr = np;
    e.tag = tag;
    sb.push_back(e);
    model_ptr   = np;
    req_valid   = 1'b1;
    req_op      = op;
    req_osize   = os;
    req_asize   = as;
    req_selpush = sel;
    req_rel     = rel;
    seg_base    = base;
    @(negedge clk);
    req_valid   = 1'b0;
  endtask

  task automatic do_load(logic [63:0] val, logic with_push);
    load_en   = 1'b1;
    load_val  = val;
    req_valid = with_push;
    req_op    = 2'd0;
    req_asize = 2'd2;
    req_osize = 2'd2;
    @(negedge clk);
    load_en   = 1'b0;
    req_valid = 1'b0;
    model_ptr = val;
    chk("R10", "load ptr", rsp_ptr, val);
    chk("R10", "load no rsp", {63'd0, rsp_valid}, 64'd0);
  endtask

  // Monitor: compares each response against the queue front.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        chk("R11", "unexpected rsp", 64'd1, 64'd0);
      end else begin
        got = sb.pop_front();
        chk(got.tag, "addr", rsp_addr, got.addr);
        chk(got.tag, "ptr", rsp_ptr, got.ptr);
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_op = 0; req_osize = 0; req_asize = 0;
    req_selpush = 0; req_rel = 0; load_en = 0; load_val = 0; seg_base = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "rst valid", {63'd0, rsp_valid}, 64'd0);
    chk("R12", "rst ptr", rsp_ptr, 64'd0);
    chk("R12", "rst addr", rsp_addr, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R10: load, then R1/R3/R8 64-bit pushes with a base that must be ignored
    do_load(64'h0000_0000_0000_1000, 1'b0);
    issue(2'd0, 2'd2, 2'd2, 1'b0, 16'd0, 64'hDEAD_0000, "R1_R8");
    issue(2'd0, 2'd1, 2'd3, 1'b0, 16'd0, 64'hDEAD_0000, "R3");
    issue(2'd1, 2'd1, 2'd2, 1'b0, 16'd0, 64'hDEAD_0000, "R2");
    issue(2'd1, 2'd3, 2'd2, 1'b0, 16'd0, 64'h0, "R2_R3");
    // R5: 2-byte push on a 32-bit stack, with base added
    issue(2'd0, 2'd0, 2'd1, 1'b0, 16'd0, 64'h0001_0000, "R5");
    // R4: selector pushes on each stack width
    issue(2'd0, 2'd0, 2'd1, 1'b1, 16'd0, 64'h0001_0000, "R4");
    issue(2'd0, 2'd0, 2'd2, 1'b1, 16'd0, 64'h0, "R4");
    issue(2'd0, 2'd2, 2'd0, 1'b1, 16'd0, 64'h0002_0000, "R4");
    issue(2'd3, 2'd0, 2'd1, 1'b0, 16'd0, 64'h0001_0000, "R2");
    // R6: 16-bit wrap with upper bits kept
    do_load(64'hABCD_0000_1234_0002, 1'b0);
    issue(2'd0, 2'd1, 2'd0, 1'b0, 16'd0, 64'h0003_0000, "R6");
    issue(2'd1, 2'd1, 2'd0, 1'b0, 16'd0, 64'h0003_0000, "R6");
    issue(2'd1, 2'd0, 2'd0, 1'b0, 16'd0, 64'h0003_0000, "R6");
    // R7: 32-bit wrap with upper bits kept
    do_load(64'h5555_5555_0000_0004, 1'b0);
    issue(2'd0, 2'd2, 2'd1, 1'b0, 16'd0, 64'h0100_0000, "R7");
    issue(2'd1, 2'd2, 2'd1, 1'b0, 16'd0, 64'h0100_0000, "R7");
    // R9: pop and release
    issue(2'd2, 2'd1, 2'd1, 1'b0, 16'h0010, 64'h0100_0000, "R9");
    do_load(64'h0000_0000_0000_8000, 1'b0);
    issue(2'd2, 2'd2, 2'd2, 1'b0, 16'hFFF0, 64'h0, "R9");
    // R10: load overrides a push in the same cycle
    do_load(64'h0000_0000_0000_4000, 1'b1);
    // R11: idle cycles leave the pointer and valid alone
    repeat (3) @(negedge clk);
    chk("R11", "idle ptr", rsp_ptr, model_ptr);
    chk("R11", "idle valid", {63'd0, rsp_valid}, 64'd0);
    issue(2'd0, 2'd2, 2'd2, 1'b0, 16'd0, 64'h0, "R1");
    repeat (2) @(negedge clk);
    chk("R11", "queue drained", 64'(sb.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule